// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a two-level logic array that can be configured in the field. Each of its `P_TERMS` product terms is an AND over the `N_IN` inputs. Every input takes part in a term as its true form, as its complement, or not at all. Each of the `M_OUT` outputs is the OR of the product terms selected by its connection mask. One product term can feed several outputs, so a term that several outputs need is built once and not repeated.

The personality is loaded serially. Bits are shifted into a shadow register while a shift enable is high. A one-cycle load strobe then copies the whole shadow into the active personality in a single step, so the outputs never show a half-loaded configuration. From inputs to outputs the path is purely combinational. In PAL mode (`PAL_MODE=1`) the OR connections are fixed when the design is elaborated, and only the AND plane is loaded. Output `o` is then fed by the `PAL_TPO` terms `o, o+1, …`, wrapping modulo `P_TERMS`.

Top module: `pla_array`

## Requirements
- R1: In the AND plane, the 2-bit code for input `i` in term `t` sits at bits `[2*(t*N_IN+i)+1 : 2*(t*N_IN+i)]` of the personality vector. Code 01 ANDs the true input into the term, code 10 ANDs the complemented input, and code 00 leaves the input out.
- R2: If any literal of a term holds code 11, that term evaluates to 0 whatever the inputs are.
- R3: A term whose literals are all code 00 evaluates to 1. An output with no connected terms evaluates to 0.
- R4: In PLA mode, bit `N_IN*P_TERMS*2 + o*P_TERMS + t` of the personality connects term `t` to output `o` when it is 1. A single term may be connected to several outputs at once.
- R5: On each rising clock edge with `cfg_en_i` high, the shadow register shifts left by one and takes `cfg_bit_i` into bit 0. The stream is therefore sent MSB first.
- R6: On the edge after `cfg_load_i` is seen high, the active personality takes the whole shadow. Shifting with no load leaves the outputs unchanged.
- R7: After reset, and until the first load, every output is 0.
- R8: If `cfg_en_i` and `cfg_load_i` are high in the same cycle, the load takes the shadow as it stood before that cycle's shift, and the shift still happens.
- R9: With `PAL_MODE=1`, the personality holds only the AND plane. Output `o` is connected to term `t` exactly when `(t - o) mod P_TERMS < PAL_TPO`.
- R10: The outputs follow `in_i` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Shift enable for the serial personality stream |
| cfg_bit_i | input | 1 | Serial personality bit, MSB first |
| cfg_load_i | input | 1 | Copies the shadow into the active personality |
| in_i | input | N_IN | Logic inputs |
| out_o | output | M_OUT | Sum-of-products outputs |

## Verification
A shift and a load can happen in the same cycle. The bench provokes this by raising the load strobe on the last bit of a stream. It then judges the outputs against a bench-side shadow model that captures the shadow before that bit was applied. After that, a plain load must bring in the full stream. Shift-only phases are checked to leave the outputs unchanged. A PAL-mode instance receives the same stream. Its outputs are judged against the fixed connection window, using the low AND-plane bits of the stream.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_e;
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_en_i,
  input  logic         cfg_bit_i,
  input  logic         cfg_load_i,
  output logic [W-1:0] active_o,
  output logic         loaded_o
);
  logic [W-1:0] shadow_q, active_q;
  logic         loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (cfg_en_i) shadow_q <= {shadow_q[W-2:0], cfg_bit_i};
      if (cfg_load_i) begin
        active_q <= shadow_q;   // pre-shift shadow on a same-cycle shift
        loaded_q <= 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign loaded_o = loaded_q;

  // R5
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> shadow_q[0] == $past(cfg_bit_i));
  // R6
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i |=> (active_q == $past(shadow_q)) && loaded_q);
  // R6
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(active_q));
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN    = 3,
  parameter int P_TERMS = 5,
  localparam int AND_W  = 2 * N_IN * P_TERMS
) (
  input  logic [N_IN-1:0]    in_i,
  input  logic [AND_W-1:0]   and_cfg_i,
  output logic [P_TERMS-1:0] term_o
);
  for (genvar t = 0; t < P_TERMS; t++) begin : g_term
    always_comb begin
      term_o[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        case (lit_e'(and_cfg_i[2*(t*N_IN+i) +: 2]))
          LIT_TRUE: term_o[t] = term_o[t] & in_i[i];
          LIT_COMP: term_o[t] = term_o[t] & ~in_i[i];
          LIT_KILL: term_o[t] = 1'b0;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int P_TERMS = 5,
  parameter int M_OUT   = 4,
  localparam int OR_W   = P_TERMS * M_OUT
) (
  input  logic [P_TERMS-1:0] term_i,
  input  logic [OR_W-1:0]    conn_i,
  output logic [M_OUT-1:0]   sum_o
);
  for (genvar o = 0; o < M_OUT; o++) begin : g_out
    assign sum_o[o] = |(term_i & conn_i[o*P_TERMS +: P_TERMS]);
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN     = 3,
  parameter int P_TERMS  = 5,
  parameter int M_OUT    = 4,
  parameter bit PAL_MODE = 1'b0,
  parameter int PAL_TPO  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic             cfg_load_i,
  input  logic [N_IN-1:0]  in_i,
  output logic [M_OUT-1:0] out_o
);
  localparam int AND_W = 2 * N_IN * P_TERMS;
  localparam int OR_W  = P_TERMS * M_OUT;
  localparam int CFG_W = PAL_MODE ? AND_W : AND_W + OR_W;

  function automatic logic [OR_W-1:0] fixed_conn();
    logic [OR_W-1:0] m;
    m = '0;
    for (int o = 0; o < M_OUT; o++)
      for (int t = 0; t < P_TERMS; t++)
        if (((t - o + M_OUT * P_TERMS) % P_TERMS) < PAL_TPO) m[o*P_TERMS+t] = 1'b1;
    return m;
  endfunction

  logic [CFG_W-1:0]   active;
  logic               loaded;
  logic [OR_W-1:0]    conn;
  logic [P_TERMS-1:0] term;
  logic [M_OUT-1:0]   sum;

  pla_cfg_store #(.W(CFG_W)) u_store (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_bit_i, .cfg_load_i,
    .active_o(active), .loaded_o(loaded)
  );

  if (PAL_MODE) begin : g_pal
    assign conn = fixed_conn();
  end else begin : g_pla
    assign conn = active[CFG_W-1:AND_W];
  end

  pla_and_plane #(.N_IN(N_IN), .P_TERMS(P_TERMS)) u_and (
    .in_i, .and_cfg_i(active[AND_W-1:0]), .term_o(term)
  );

  pla_or_plane #(.P_TERMS(P_TERMS), .M_OUT(M_OUT)) u_or (
    .term_i(term), .conn_i(conn), .sum_o(sum)
  );

  assign out_o = loaded ? sum : '0;

  // R7
  unloaded_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded |-> out_o == '0);

  for (genvar t = 0; t < P_TERMS; t++) begin : g_kchk
    logic has_kill;
    always_comb begin
      has_kill = 1'b0;
      for (int i = 0; i < N_IN; i++)
        if (active[2*(t*N_IN+i) +: 2] == 2'b11) has_kill = 1'b1;
    end
    // R2
    kill_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      has_kill |-> !term[t]);
  end

  for (genvar o = 0; o < M_OUT; o++) begin : g_echk
    // R3
    empty_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conn[o*P_TERMS +: P_TERMS] == '0) |-> !out_o[o]);
  end
endmodule

// File: tb/tb_pla_array.sv
`timescale 1ns/1ps
module tb_pla_array;
  localparam int N = 3, P = 5, M = 4, TPO = 4;
  localparam int AW = 2*N*P, CW = AW + P*M;

  logic clk_i = 0, rst_ni = 0;
  logic cfg_en_i = 0, cfg_bit_i = 0, cfg_load_i = 0;
  logic [N-1:0] in_i = '0;
  logic [M-1:0] out_o, out_pal;

  int checks = 0, fails = 0;
  logic [CW-1:0] shadow_m = '0, active_m = '0, bv;
  bit loaded_m = 0;

  always #2.5 clk_i = ~clk_i;

  pla_array #(.N_IN(N), .P_TERMS(P), .M_OUT(M), .PAL_MODE(1'b0)) dut (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_bit_i, .cfg_load_i, .in_i, .out_o);
  pla_array #(.N_IN(N), .P_TERMS(P), .M_OUT(M), .PAL_MODE(1'b1), .PAL_TPO(TPO)) dut_pal (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_bit_i, .cfg_load_i, .in_i, .out_o(out_pal));

  function automatic logic [M-1:0] eval(logic [CW-1:0] v, logic [N-1:0] x, bit pal, bit ld);
    logic [P-1:0] tm;
    logic [M-1:0] r;
    if (!ld) return '0;
    for (int t = 0; t < P; t++) begin
      tm[t] = 1'b1;
      for (int i = 0; i < N; i++) begin
        logic [1:0] c;
        c = v[2*(t*N+i) +: 2];
        if (c == 2'b01 && !x[i]) tm[t] = 1'b0;
        if (c == 2'b10 && x[i]) tm[t] = 1'b0;
        if (c == 2'b11) tm[t] = 1'b0;
      end
    end
    for (int o = 0; o < M; o++) begin
      r[o] = 1'b0;
      for (int t = 0; t < P; t++) begin
        bit cn;
        cn = pal ? (((t - o + P) % P) < TPO) : v[AW + o*P + t];
        if (cn && tm[t]) r[o] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check_all(string req);
    for (int x = 0; x < (1 << N); x++) begin
      logic [M-1:0] e, ep;
      in_i = x[N-1:0];
      #1;
      e  = eval(active_m, x[N-1:0], 0, loaded_m);
      ep = eval(active_m, x[N-1:0], 1, loaded_m);
      checks += 2;
      if (out_o !== e) begin
        fails++;
        $display("FAIL %s pla in=%0d out=%b expected=%b", req, x, out_o, e);
      end
      if (out_pal !== ep) begin
        fails++;
        $display("FAIL %s pal in=%0d out=%b expected=%b", req, x, out_pal, ep);
      end
    end
  endtask

  // shifts all CW bits MSB first; load_last raises the load on the final bit
  task automatic shift_vec(logic [CW-1:0] v, bit load_last);
    for (int b = CW-1; b >= 0; b--) begin
      @(negedge clk_i);
      cfg_en_i = 1; cfg_bit_i = v[b];
      cfg_load_i = load_last && (b == 0);
      @(posedge clk_i);
      if (cfg_load_i) begin active_m = shadow_m; loaded_m = 1; end
      shadow_m = {shadow_m[CW-2:0], v[b]};
    end
    @(negedge clk_i);
    cfg_en_i = 0; cfg_load_i = 0;
  endtask

  task automatic do_load();
    @(negedge clk_i);
    cfg_load_i = 1;
    @(posedge clk_i);
    active_m = shadow_m; loaded_m = 1;
    @(negedge clk_i);
    cfg_load_i = 0;
  endtask

  function automatic logic [CW-1:0] set_lit(logic [CW-1:0] v, int t, int i, logic [1:0] c);
    v[2*(t*N+i) +: 2] = c;
    return v;
  endfunction

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R7: reset state
    check_all("R7");

    // F0 = A + B.C' ; t0=A, t1=B.C', t2=A.C, t3=B', t4=all don't care
    bv = '0;
    bv = set_lit(bv, 0, 0, 2'b01);
    bv = set_lit(bv, 1, 1, 2'b01); bv = set_lit(bv, 1, 2, 2'b10);
    bv = set_lit(bv, 2, 0, 2'b01); bv = set_lit(bv, 2, 2, 2'b01);
    bv = set_lit(bv, 3, 1, 2'b10);
    bv[AW + 0*P + 0] = 1; bv[AW + 0*P + 1] = 1;
    bv[AW + 1*P + 1] = 1; bv[AW + 1*P + 2] = 1;
    bv[AW + 2*P + 3] = 1; bv[AW + 2*P + 0] = 1;
    bv[AW + 3*P + 4] = 1;
    shift_vec(bv, 0);
    // R6: shift without load leaves outputs at their reset value
    check_all("R6");
    do_load();
    // R1 R4 R10: shared terms, combinational evaluation
    check_all("R1");
    in_i = 3'b010; #1; checks++;
    if (out_o !== 4'b1011) begin
      fails++; $display("FAIL R4 out=%b expected=%b", out_o, 4'b1011);
    end

    // R2: kill code on t0; R3: output 3 has no connections
    bv = set_lit(bv, 0, 1, 2'b11);
    bv[AW + 3*P +: P] = '0;
    shift_vec(bv, 0);
    do_load();
    check_all("R2");
    in_i = 3'b001; #1; checks++;
    if (out_o[3] !== 1'b0 || out_o[0] !== 1'b0) begin
      fails++; $display("FAIL R3 out=%b expected=0xx0", out_o);
    end

    // R8: load on the final bit of a stream takes the pre-shift shadow
    bv = {$urandom, $urandom};
    shift_vec(bv, 1);
    check_all("R8");
    do_load();
    check_all("R5");

    // R9 R4 R1: random personalities on both instances
    for (int k = 0; k < 40; k++) begin
      bv = {$urandom, $urandom};
      shift_vec(bv, (k % 5) == 4);
      check_all("R6");
      do_load();
      check_all("R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule